// File: doc/BRIEF.md
# USB Controller Interrupt Collector with Rearm Gate

This block sits beside a USB on-the-go controller. It gathers the controller's interrupt events into two latched groups: one for endpoint traffic and one for controller-wide events. Each group has a source register, a mask register and a masked view. Software reaches them over a plain 32-bit register bus. Each source and each mask is changed through separate write-one-to-set and write-one-to-clear aliases, so no read-modify-write is needed. Software can also inject a source bit, for example the vbus-drive event, to start its own polling.

A single level interrupt line combines both masked groups. Once the line has been raised and the handler has cleared the pending bits, the line stays low, even if new events arrive. It rises again only after software writes any value to the end-of-interrupt register. A control register carries a self-clearing soft-reset bit for the controller. A read-only identification word lets software confirm that the block is clocked.

Top module: `usb_irq_glue`

## Requirements
- R1: After reset, every source and mask register reads zero and `irq` is low.
- R2: A one on `ep_evt` or `core_evt` is latched into the matching source bit on the next clock edge. A hardware event wins over a clear-alias write to the same bit in the same cycle.
- R3: The source-set aliases (0x24 endpoint, 0x44 core) OR written ones into the source. The source-clear aliases (0x28, 0x48) remove them. Core bits sit at bus bits 24:16, and bus bit 24 is the vbus-drive event. All other core bus bits read zero and ignore writes.
- R4: Endpoint bit 16 (receive endpoint 0) does not exist. It reads zero in the source at 0x20 and in the mask at 0x2C, whatever is written. Endpoint bits 15:0 are transmit endpoints 0 to 15, and bits 31:17 are receive endpoints 1 to 15.
- R5: The mask-set aliases (0x30, 0x50) and mask-clear aliases (0x34, 0x50+4) change the masks. The masks are readable at 0x2C and 0x4C.
- R6: The masked views at 0x38 and 0x58 read source AND mask.
- R7: While the block is armed, `irq` rises one clock edge after any masked bit becomes nonzero. That is two edges after the event input is sampled.
- R8: Once `irq` has been high and all masked bits have cleared, `irq` falls one edge later. It stays low through new events until a write of any value to 0x60, after which it may rise again one edge later.
- R9: Writing 1 to bit 0 of 0x04 drives `core_soft_rst` high for exactly one cycle. At the next edge every source and mask is cleared and the rearm gate returns to armed. Soft reset wins over events in that cycle.
- R10: Reads of the set, clear and end-of-interrupt aliases, the control register and the reserved offsets 0x10 and 0x5C return zero. Writes to reserved offsets change nothing.
- R11: Offset 0x00 reads the nonzero identification constant 0x00010A03. Offset 0x08 bit 0 reads the `vbus_sense` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ep_evt | input | 32 | Endpoint event pulses in the endpoint bus layout |
| core_evt | input | 9 | Controller event pulses; bit 8 is vbus drive |
| vbus_sense | input | 1 | Live vbus-drive status, shown at 0x08 |
| irq | output | 1 | Level interrupt request |
| core_soft_rst | output | 1 | One-cycle reset pulse to the controller |

## Verification
A wrong source or mask bit shows up right away, in the same cycle, on a read of the source, mask or masked view. The bench therefore compares every alias write against the three readable views. A fault in the rearm gate only appears at `irq`, and only with a lag. The bench samples `irq` at the exact edges where it must stay low and where it must rise, both before and after the end-of-interrupt write. A missing dip or an early re-assertion then shows within one or two cycles.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int AW       = 8;
  localparam int DW       = 32;
  localparam int CORE_W   = 9;
  localparam int CORE_LSB = 16;

  localparam logic [AW-1:0] A_IDENT  = 8'h00;
  localparam logic [AW-1:0] A_CTRL   = 8'h04;
  localparam logic [AW-1:0] A_STAT   = 8'h08;
  localparam logic [AW-1:0] A_EP     = 8'h20;
  localparam logic [AW-1:0] A_CORE   = 8'h40;
  localparam logic [AW-1:0] A_REARM  = 8'h60;

  // Offsets within a group, relative to its base.
  localparam logic [AW-1:0] G_SRC   = 8'h00;
  localparam logic [AW-1:0] G_SSET  = 8'h04;
  localparam logic [AW-1:0] G_SCLR  = 8'h08;
  localparam logic [AW-1:0] G_MSK   = 8'h0C;
  localparam logic [AW-1:0] G_MSET  = 8'h10;
  localparam logic [AW-1:0] G_MCLR  = 8'h14;
  localparam logic [AW-1:0] G_MVIEW = 8'h18;

  typedef enum logic [1:0] {ST_ARMED, ST_RAISED, ST_SERVED} gate_t;

  function automatic logic [CORE_W-1:0] core_take(input logic [DW-1:0] w);
    return w[CORE_LSB +: CORE_W];
  endfunction

  function automatic logic [DW-1:0] core_place(input logic [CORE_W-1:0] f);
    logic [DW-1:0] r;
    r = '0;
    r[CORE_LSB +: CORE_W] = f;
    return r;
  endfunction

  function automatic logic [DW-1:0] merge_src(input logic [DW-1:0] cur, input logic [DW-1:0] s,
                                              input logic [DW-1:0] c, input logic [DW-1:0] ev);
    return ((cur | s) & ~c) | ev;
  endfunction
endpackage

// File: rtl/irqg_group.sv
module irqg_group #(
  parameter int W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] src_set,
  input  logic [W-1:0] src_clr,
  input  logic [W-1:0] msk_set,
  input  logic [W-1:0] msk_clr,
  output logic [W-1:0] src_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] masked
);
  logic [W-1:0] src_d, msk_d;

  always_comb begin
    src_d = ((src_q | src_set) & ~src_clr) | evt;
    msk_d = (msk_q | msk_set) & ~msk_clr;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          src_q[i] <= 1'b0;
          msk_q[i] <= 1'b0;
        end else if (soft_clr) begin
          src_q[i] <= 1'b0;
          msk_q[i] <= 1'b0;
        end else begin
          src_q[i] <= src_d[i];
          msk_q[i] <= msk_d[i];
        end
      end
    end else begin : g_absent
      assign src_q[i] = 1'b0;
      assign msk_q[i] = 1'b0;
    end
  end

  assign masked = src_q & msk_q;
endmodule

// File: rtl/irqg_gate.sv
module irqg_gate
  import irqg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic pending,
  input  logic rearm_wr,
  output logic irq
);
  gate_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ARMED:  if (pending)  st_d = ST_RAISED;
      ST_RAISED: if (!pending) st_d = ST_SERVED;
      default:   st_d = ST_SERVED;
    endcase
    if (rearm_wr || soft_clr) st_d = ST_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_ARMED;
    else        st_q <= st_d;
  end

  assign irq = (st_q == ST_RAISED);
endmodule

// File: rtl/usb_irq_glue.sv
module usb_irq_glue
  import irqg_pkg::*;
#(
  parameter logic [31:0] IDENT    = 32'h0001_0A03,
  parameter logic [31:0] EP_VALID = 32'hFFFE_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     ep_evt,
  input  logic [CORE_W-1:0] core_evt,
  input  logic              vbus_sense,
  output logic              irq,
  output logic              core_soft_rst
);
  logic              soft_q;
  logic              rearm_wr, soft_wr, pending;
  logic [DW-1:0]     ep_src, ep_msk, ep_masked;
  logic [CORE_W-1:0] core_src, core_msk, core_masked;
  logic [DW-1:0]     ep_sset, ep_sclr, ep_mset, ep_mclr;
  logic [CORE_W-1:0] co_sset, co_sclr, co_mset, co_mclr;

  function automatic logic hit(input logic [AW-1:0] a, input logic [AW-1:0] base,
                               input logic [AW-1:0] off);
    return a == (base + off);
  endfunction

  always_comb begin
    ep_sset = (reg_wr && hit(reg_addr, A_EP, G_SSET)) ? reg_wdata : '0;
    ep_sclr = (reg_wr && hit(reg_addr, A_EP, G_SCLR)) ? reg_wdata : '0;
    ep_mset = (reg_wr && hit(reg_addr, A_EP, G_MSET)) ? reg_wdata : '0;
    ep_mclr = (reg_wr && hit(reg_addr, A_EP, G_MCLR)) ? reg_wdata : '0;
    co_sset = (reg_wr && hit(reg_addr, A_CORE, G_SSET)) ? core_take(reg_wdata) : '0;
    co_sclr = (reg_wr && hit(reg_addr, A_CORE, G_SCLR)) ? core_take(reg_wdata) : '0;
    co_mset = (reg_wr && hit(reg_addr, A_CORE, G_MSET)) ? core_take(reg_wdata) : '0;
    co_mclr = (reg_wr && hit(reg_addr, A_CORE, G_MCLR)) ? core_take(reg_wdata) : '0;
  end

  assign rearm_wr = reg_wr && (reg_addr == A_REARM);
  assign soft_wr  = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= soft_wr && !soft_q;
  end
  assign core_soft_rst = soft_q;

  irqg_group #(.W(DW), .VALID(EP_VALID)) u_ep (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_q), .evt(ep_evt),
    .src_set(ep_sset), .src_clr(ep_sclr), .msk_set(ep_mset), .msk_clr(ep_mclr),
    .src_q(ep_src), .msk_q(ep_msk), .masked(ep_masked)
  );

  irqg_group #(.W(CORE_W), .VALID({CORE_W{1'b1}})) u_core (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_q), .evt(core_evt),
    .src_set(co_sset), .src_clr(co_sclr), .msk_set(co_mset), .msk_clr(co_mclr),
    .src_q(core_src), .msk_q(core_msk), .masked(core_masked)
  );

  assign pending = (|ep_masked) || (|core_masked);

  irqg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_q), .pending(pending),
    .rearm_wr(rearm_wr), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_IDENT:              reg_rdata = IDENT;
      A_STAT:               reg_rdata = {{(DW-1){1'b0}}, vbus_sense};
      A_EP + G_SRC:         reg_rdata = ep_src;
      A_EP + G_MSK:         reg_rdata = ep_msk;
      A_EP + G_MVIEW:       reg_rdata = ep_masked;
      A_CORE + G_SRC:       reg_rdata = core_place(core_src);
      A_CORE + G_MSK:       reg_rdata = core_place(core_msk);
      A_CORE + G_MVIEW:     reg_rdata = core_place(core_masked);
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqg_checker.sv
module irqg_checker
  import irqg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              soft_rst,
  input logic              rearm_wr,
  input logic              pending,
  input logic [DW-1:0]     ep_src,
  input logic [DW-1:0]     ep_masked,
  input logic [CORE_W-1:0] core_masked
);
  // R7: a rising request is always backed by a masked bit one edge earlier
  assert_rise_backed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pending));

  // R8: a rearm write leaves the line low for the following cycle
  assert_rearm_dip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_wr && !soft_rst) |=> !irq);

  // R9: the soft-reset pulse lasts exactly one cycle
  assert_soft_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  // R9: after the pulse nothing is pending and the line is low
  assert_soft_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ep_masked == '0 && core_masked == '0 && !irq));

  // R4: receive endpoint 0 never holds a bit
  assert_no_rx0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_src[16]);
endmodule

bind usb_irq_glue irqg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .soft_rst(core_soft_rst),
  .rearm_wr(rearm_wr), .pending(pending), .ep_src(ep_src),
  .ep_masked(ep_masked), .core_masked(core_masked)
);

// File: tb/tb_usb_irq_glue.sv
module tb_usb_irq_glue;
  localparam time PERIOD = 10ns;
  localparam logic [31:0] IDENT = 32'h0001_0A03;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, IDENT,        4'd11}, // R11 identification
    '{1'b0, 8'h20, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h40, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h2C, 32'h0,        4'd1},  // R1
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 4'd3}, // R3 set all
    '{1'b0, 8'h20, 32'hFFFE_FFFF, 4'd4}, // R4 rx0 absent
    '{1'b1, 8'h28, 32'h0000_00FF, 4'd3}, // R3 clear
    '{1'b0, 8'h20, 32'hFFFE_FF00, 4'd3},
    '{1'b1, 8'h30, 32'h0001_0F0F, 4'd5}, // R5 mask set
    '{1'b0, 8'h2C, 32'h0000_0F0F, 4'd4}, // R4 mask rx0 absent
    '{1'b0, 8'h38, 32'h0000_0F00, 4'd6}, // R6
    '{1'b1, 8'h34, 32'h0000_0F00, 4'd5}, // R5 mask clear
    '{1'b0, 8'h2C, 32'h0000_000F, 4'd5},
    '{1'b0, 8'h38, 32'h0,        4'd6},  // R6
    '{1'b1, 8'h44, 32'hFFFF_FFFF, 4'd3}, // R3 core set
    '{1'b0, 8'h40, 32'h01FF_0000, 4'd3},
    '{1'b1, 8'h48, 32'h0100_0000, 4'd3}, // R3 clear vbus-drive bit
    '{1'b0, 8'h40, 32'h00FF_0000, 4'd3},
    '{1'b1, 8'h50, 32'h0103_0000, 4'd5},
    '{1'b0, 8'h4C, 32'h0103_0000, 4'd5},
    '{1'b0, 8'h58, 32'h0003_0000, 4'd6},
    '{1'b0, 8'h24, 32'h0,        4'd10}, // R10 alias reads
    '{1'b0, 8'h60, 32'h0,        4'd10},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 4'd10},
    '{1'b0, 8'h10, 32'h0,        4'd10},
    '{1'b0, 8'h5C, 32'h0,        4'd10},
    '{1'b0, 8'h48, 32'h0,        4'd10},
    '{1'b0, 8'h08, 32'h0,        4'd11}  // R11 status
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ep_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_sense = 1'b0;
  logic        irq, core_soft_rst;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  usb_irq_glue dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ep_evt(ep_evt),
    .core_evt(core_evt), .vbus_sense(vbus_sense), .irq(irq),
    .core_soft_rst(core_soft_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else rd($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
    end

    // R9 soft reset pulse and clearing
    wr(8'h04, 32'h1);
    check("R9 pulse high", {31'b0, core_soft_rst}, 32'h1);
    @(negedge clk);
    check("R9 pulse low", {31'b0, core_soft_rst}, 32'h0);
    rd("R9 ep src", 8'h20, 32'h0);
    rd("R9 core src", 8'h40, 32'h0);
    rd("R9 ep mask", 8'h2C, 32'h0);
    rd("R9 core mask", 8'h4C, 32'h0);
    rd("R10 ctrl read", 8'h04, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);

    // R11 status input
    vbus_sense = 1'b1;
    rd("R11 status", 8'h08, 32'h1);
    vbus_sense = 1'b0;

    // R2 event latched; event beats same-cycle clear
    @(negedge clk);
    reg_addr = 8'h28; reg_wdata = 32'h20; reg_wr = 1'b1; ep_evt = 32'h20;
    @(negedge clk);
    reg_wr = 1'b0; ep_evt = '0;
    rd("R2 event wins", 8'h20, 32'h20);
    @(negedge clk);
    core_evt = 9'h100;
    @(negedge clk);
    core_evt = '0;
    rd("R2 core event", 8'h40, 32'h0100_0020 & 32'h0100_0000);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);

    // R7 latency
    wr(8'h30, 32'h8);
    @(negedge clk);
    ep_evt = 32'h8;
    @(negedge clk);
    ep_evt = '0;
    check("R7 not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 raised", {31'b0, irq}, 32'h1);

    // R8 service then hold low until rearm
    wr(8'h28, 32'h8);
    check("R8 still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 dropped", {31'b0, irq}, 32'h0);
    @(negedge clk);
    ep_evt = 32'h8;
    @(negedge clk);
    ep_evt = '0;
    repeat (3) @(negedge clk);
    check("R8 held low", {31'b0, irq}, 32'h0);
    wr(8'h60, 32'h0);
    check("R8 after rearm edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 re-raised", {31'b0, irq}, 32'h1);

    finish_run();
  end
endmodule